// File: doc/BRIEF.md
# Two-Parallel Fast Four-Tap FIR Filter

This block is a four-tap FIR filter that takes two input samples per clock and returns two output samples per clock. Each clock carries one block. The even port holds the earlier sample x(2k) and the odd port holds the later sample x(2k+1). The outputs are y(2k) on the even port and y(2k+1) on the odd port, where y(n) = h0·x(n) + h1·x(n-1) + h2·x(n-2) + h3·x(n-3).

The block does not run two full copies of the filter. It uses three two-tap subfilters:
- one applies the even coefficients to the even samples;
- one applies the odd coefficients to the odd samples;
- one applies the coefficient sums (h0+h1, h2+h3) to the pre-added sample pair.

The even output adds the odd-phase subfilter result from the previous block to the even-phase result. The odd output subtracts both direct results from the cross result. This needs six multipliers instead of eight.

Every delay inside the structure spans one block, and it advances only on a valid block. A two-stage pipeline gives a fixed latency of two clocks. Coefficients are static inputs that the surrounding logic sets while the filter is idle or held in reset.

Top module: `parfir_fast2`

## Requirements
- R1: On a valid block, `outEven` equals h0·x(2k) + h1·x(2k-1) + h2·x(2k-2) + h3·x(2k-3). All samples and coefficients are signed two's complement. `inEven` carries x(2k), and `inOdd` carries x(2k+1) of the same block.
- R2: On a valid block, `outOdd` equals h0·x(2k+1) + h1·x(2k) + h2·x(2k-1) + h3·x(2k-2).
- R3: Results are exact for every input and coefficient value, including all operands at the most negative code. No intermediate sum or difference overflows.
- R4: `outValid` is high exactly two clock cycles after a cycle in which `inValid` was sampled high, and at no other time.
- R5: Cycles with `inValid` low do not advance the filter history. A block that follows a gap sees, as x(n-1..n-3), the samples of the last valid blocks.
- R6: While `rstN` is low, `outValid`, `outEven` and `outOdd` are zero. The sample history is cleared, so the first blocks after reset treat earlier samples as zero.
- R7: `outEven` and `outOdd` keep their last values in every cycle where `outValid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Input block present |
| inEven | input | DATA_W | Sample x(2k), signed |
| inOdd | input | DATA_W | Sample x(2k+1), signed |
| coef0 | input | COEF_W | Tap h0, signed |
| coef1 | input | COEF_W | Tap h1, signed |
| coef2 | input | COEF_W | Tap h2, signed |
| coef3 | input | COEF_W | Tap h3, signed |
| outValid | output | 1 | Output block present |
| outEven | output | DATA_W+COEF_W+2 | Result y(2k), signed |
| outOdd | output | DATA_W+COEF_W+2 | Result y(2k+1), signed |

## Verification
The assertions assume three things about the inputs:
- the coefficients stay fixed while blocks are in flight;
- `inValid` is a clean level sampled at the rising edge;
- `inValid` is low while reset is applied.

The bench respects these assumptions. It changes coefficient sets only while `rstN` is low and the pipeline is empty, and it holds `inValid` low through every reset. Inside those bounds it sweeps every sample pair of a four-bit configuration against several coefficient sets, including the all-most-negative set. Idle gaps are mixed into the stream so that history retention is observed at the outputs.

// File: rtl/parfir_pkg.sv
package parfir_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadStage1;   // capture subfilter results and advance history
    logic loadStage2;   // combine into output registers
  } parfir_strobe_t;

  localparam int NUM_SUB = 3;   // subfilter count: even, odd, cross
  localparam int SUB_EVEN  = 0;
  localparam int SUB_ODD   = 1;
  localparam int SUB_CROSS = 2;

endpackage

// File: rtl/parfir_tap2.sv
module parfir_tap2 #(
  parameter int SAMP_W = 9,
  parameter int CF_W   = 9,
  parameter int ACC_W  = 20
) (
  input  logic signed [SAMP_W-1:0] sampleNow,
  input  logic signed [SAMP_W-1:0] samplePrev,
  input  logic signed [CF_W-1:0]   coefNow,
  input  logic signed [CF_W-1:0]   coefPrev,
  output logic signed [ACC_W-1:0]  tapSum
);
  localparam int PROD_W = SAMP_W + CF_W;

  logic signed [PROD_W-1:0] prodNow;
  logic signed [PROD_W-1:0] prodPrev;
  logic signed [ACC_W-1:0]  prodNowExt;
  logic signed [ACC_W-1:0]  prodPrevExt;

  assign prodNow     = sampleNow * coefNow;
  assign prodPrev    = samplePrev * coefPrev;
  assign prodNowExt  = prodNow;
  assign prodPrevExt = prodPrev;
  assign tapSum      = prodNowExt + prodPrevExt;
endmodule

// File: rtl/parfir_ctrl.sv
module parfir_ctrl
  import parfir_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           inValid,
  output parfir_strobe_t strobe,
  output logic           outValid
);
  logic       s1Valid;
  logic       s2Valid;
  logic [1:0] ageCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s2Valid <= 1'b0;
      ageCnt  <= 2'd0;
    end else begin
      s1Valid <= inValid;
      s2Valid <= s1Valid;
      if (ageCnt != 2'd2) ageCnt <= ageCnt + 2'd1;
    end
  end

  assign strobe.loadStage1 = inValid;
  assign strobe.loadStage2 = s1Valid;
  assign outValid          = s2Valid;

  // R4: output strobe follows input strobe by exactly two edges
  a_r4_latency: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd2) |-> (outValid == $past(inValid, 2)));

  // R6: right after reset no output block is flagged
  a_r6_reset_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd0) |-> !outValid);
endmodule

// File: rtl/parfir_datapath.sv
module parfir_datapath
  import parfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  parfir_strobe_t                    strobe,
  input  logic signed [DATA_W-1:0]          inEven,
  input  logic signed [DATA_W-1:0]          inOdd,
  input  logic signed [COEF_W-1:0]          coef0,
  input  logic signed [COEF_W-1:0]          coef1,
  input  logic signed [COEF_W-1:0]          coef2,
  input  logic signed [COEF_W-1:0]          coef3,
  output logic signed [DATA_W+COEF_W+1:0]   outEven,
  output logic signed [DATA_W+COEF_W+1:0]   outOdd
);
  localparam int EXT_D = DATA_W + 1;
  localparam int EXT_C = COEF_W + 1;
  localparam int ACC_W = EXT_D + EXT_C + 2;
  localparam int OUT_W = DATA_W + COEF_W + 2;

  // Sign-extended operands with one guard bit
  logic signed [EXT_D-1:0] evenExt, oddExt, pairSum;
  logic signed [EXT_C-1:0] c0Ext, c1Ext, c2Ext, c3Ext, cfLo, cfHi;

  assign evenExt = inEven;
  assign oddExt  = inOdd;
  assign pairSum = evenExt + oddExt;
  assign c0Ext   = coef0;
  assign c1Ext   = coef1;
  assign c2Ext   = coef2;
  assign c3Ext   = coef3;
  assign cfLo    = c0Ext + c1Ext;
  assign cfHi    = c2Ext + c3Ext;

  // Block-delayed history (one block per slot)
  logic signed [EXT_D-1:0] evenPrev, oddPrev, pairPrev;
  logic signed [ACC_W-1:0] oddSubHist;

  // Subfilter operand arrays
  logic signed [EXT_D-1:0] tapNow  [NUM_SUB];
  logic signed [EXT_D-1:0] tapPrev [NUM_SUB];
  logic signed [EXT_C-1:0] tapCfA  [NUM_SUB];
  logic signed [EXT_C-1:0] tapCfB  [NUM_SUB];
  logic signed [ACC_W-1:0] tapRes  [NUM_SUB];

  always_comb begin
    tapNow[SUB_EVEN]   = evenExt;  tapPrev[SUB_EVEN]  = evenPrev;
    tapCfA[SUB_EVEN]   = c0Ext;    tapCfB[SUB_EVEN]   = c2Ext;
    tapNow[SUB_ODD]    = oddExt;   tapPrev[SUB_ODD]   = oddPrev;
    tapCfA[SUB_ODD]    = c1Ext;    tapCfB[SUB_ODD]    = c3Ext;
    tapNow[SUB_CROSS]  = pairSum;  tapPrev[SUB_CROSS] = pairPrev;
    tapCfA[SUB_CROSS]  = cfLo;     tapCfB[SUB_CROSS]  = cfHi;
  end

  for (genvar gi = 0; gi < NUM_SUB; gi++) begin : g_sub
    parfir_tap2 #(
      .SAMP_W (EXT_D),
      .CF_W   (EXT_C),
      .ACC_W  (ACC_W)
    ) u_tap (
      .sampleNow  (tapNow[gi]),
      .samplePrev (tapPrev[gi]),
      .coefNow    (tapCfA[gi]),
      .coefPrev   (tapCfB[gi]),
      .tapSum     (tapRes[gi])
    );
  end

  // Stage 1 registers
  logic signed [ACC_W-1:0] evenSubQ, oddSubQ, oddSubDelQ, crossSubQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evenPrev   <= '0;
      oddPrev    <= '0;
      pairPrev   <= '0;
      oddSubHist <= '0;
      evenSubQ   <= '0;
      oddSubQ    <= '0;
      oddSubDelQ <= '0;
      crossSubQ  <= '0;
    end else if (strobe.loadStage1) begin
      evenPrev   <= evenExt;
      oddPrev    <= oddExt;
      pairPrev   <= pairSum;
      oddSubHist <= tapRes[SUB_ODD];
      evenSubQ   <= tapRes[SUB_EVEN];
      oddSubQ    <= tapRes[SUB_ODD];
      oddSubDelQ <= oddSubHist;
      crossSubQ  <= tapRes[SUB_CROSS];
    end
  end

  // Stage 2 reconstruction
  logic signed [ACC_W-1:0] evenFull, oddFull;
  assign evenFull = evenSubQ + oddSubDelQ;
  assign oddFull  = crossSubQ - evenSubQ - oddSubQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outEven <= '0;
      outOdd  <= '0;
    end else if (strobe.loadStage2) begin
      outEven <= evenFull[OUT_W-1:0];
      outOdd  <= oddFull[OUT_W-1:0];
    end
  end

  // R3: the narrowing to the output width drops only sign copies
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadStage2 |->
      ((&oddFull[ACC_W-1:OUT_W-1]) || !(|oddFull[ACC_W-1:OUT_W-1])) &&
      ((&evenFull[ACC_W-1:OUT_W-1]) || !(|evenFull[ACC_W-1:OUT_W-1])));

  // R5: history is frozen on idle cycles
  a_r5_history_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStage1 |=> ($stable(evenPrev) && $stable(oddPrev) &&
                            $stable(pairPrev) && $stable(oddSubHist)));

  // R7: outputs hold between output blocks
  a_r7_output_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadStage2 |=> ($stable(outEven) && $stable(outOdd)));
endmodule

// File: rtl/parfir_fast2.sv
module parfir_fast2
  import parfir_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int COEF_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            inValid,
  input  logic signed [DATA_W-1:0]        inEven,
  input  logic signed [DATA_W-1:0]        inOdd,
  input  logic signed [COEF_W-1:0]        coef0,
  input  logic signed [COEF_W-1:0]        coef1,
  input  logic signed [COEF_W-1:0]        coef2,
  input  logic signed [COEF_W-1:0]        coef3,
  output logic                            outValid,
  output logic signed [DATA_W+COEF_W+1:0] outEven,
  output logic signed [DATA_W+COEF_W+1:0] outOdd
);
  parfir_strobe_t strobe;

  parfir_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  parfir_datapath #(
    .DATA_W (DATA_W),
    .COEF_W (COEF_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .inEven  (inEven),
    .inOdd   (inOdd),
    .coef0   (coef0),
    .coef1   (coef1),
    .coef2   (coef2),
    .coef3   (coef3),
    .outEven (outEven),
    .outOdd  (outOdd)
  );
endmodule

// File: tb/parfir_fast2_bench.sv
module parfir_fast2_bench;
  localparam int DW = 4;
  localparam int CW = 4;
  localparam int OW = DW + CW + 2;
  localparam int QD = 4096;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic signed [DW-1:0] inEven = '0, inOdd = '0;
  logic signed [CW-1:0] coef0 = '0, coef1 = '0, coef2 = '0, coef3 = '0;
  logic outValid;
  logic signed [OW-1:0] outEven, outOdd;

  parfir_fast2 #(.DATA_W(DW), .COEF_W(CW)) u_parfir_fast2 (
    .clk(clk), .rstN(rstN), .inValid(inValid),
    .inEven(inEven), .inOdd(inOdd),
    .coef0(coef0), .coef1(coef1), .coef2(coef2), .coef3(coef3),
    .outValid(outValid), .outEven(outEven), .outOdd(outOdd)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycle = 0;
  always @(posedge clk) cycle <= cycle + 1;

  // Expected-result queue
  int    qEven [QD];
  int    qOdd  [QD];
  int    qCyc  [QD];
  string qTagE [QD];
  string qTagO [QD];
  int wrPtr = 0;
  int rdPtr = 0;

  // Reference model state
  int h0, h1, h2, h3;
  int xm1 = 0, xm2 = 0, xm3 = 0;
  int lastEven = 0, lastOdd = 0;
  bit afterReset = 1'b0, afterGap = 1'b0, fullScale = 1'b0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // Compare outputs, sampled at the falling edge
  task automatic observe();
    if (outValid) begin
      if (rdPtr == wrPtr) begin
        check(1'b0, "R4", 1, 0);
      end else begin
        check(cycle == qCyc[rdPtr], "R4", cycle, qCyc[rdPtr]);
        check(int'(outEven) == qEven[rdPtr], qTagE[rdPtr], int'(outEven), qEven[rdPtr]);
        check(int'(outOdd)  == qOdd[rdPtr],  qTagO[rdPtr], int'(outOdd),  qOdd[rdPtr]);
        rdPtr++;
      end
      lastEven = int'(outEven);
      lastOdd  = int'(outOdd);
    end else begin
      // R7: outputs held while no block is flagged
      check(int'(outEven) == lastEven && int'(outOdd) == lastOdd, "R7",
            int'(outEven), lastEven);
    end
  endtask

  task automatic step(input bit v, input int e, input int o);
    @(negedge clk);
    observe();
    inValid = v;
    inEven  = DW'(e);
    inOdd   = DW'(o);
    if (v) begin
      qEven[wrPtr] = h0*e + h1*xm1 + h2*xm2 + h3*xm3;
      qOdd[wrPtr]  = h0*o + h1*e   + h2*xm1 + h3*xm2;
      qCyc[wrPtr]  = cycle + 2;
      if (afterReset)     begin qTagE[wrPtr] = "R6"; qTagO[wrPtr] = "R6"; end
      else if (afterGap)  begin qTagE[wrPtr] = "R5"; qTagO[wrPtr] = "R5"; end
      else if (fullScale) begin qTagE[wrPtr] = "R3"; qTagO[wrPtr] = "R3"; end
      else                begin qTagE[wrPtr] = "R1"; qTagO[wrPtr] = "R2"; end
      wrPtr++;
      xm3 = xm1;
      xm2 = e;
      xm1 = o;
      afterReset = 1'b0;
      afterGap = 1'b0;
    end else begin
      afterGap = 1'b1;
    end
  endtask

  task automatic resetWith(input int a, input int b, input int c, input int d);
    @(negedge clk);
    rstN = 1'b0;
    inValid = 1'b0;
    coef0 = CW'(a); coef1 = CW'(b); coef2 = CW'(c); coef3 = CW'(d);
    h0 = a; h1 = b; h2 = c; h3 = d;
    fullScale = (a == -8 && b == -8 && c == -8 && d == -8);
    repeat (2) @(negedge clk);
    // R6: reset state at the ports
    check(outValid == 1'b0, "R6", int'(outValid), 0);
    check(outEven == '0 && outOdd == '0, "R6", int'(outEven), 0);
    rstN = 1'b1;
    xm1 = 0; xm2 = 0; xm3 = 0;
    lastEven = 0; lastOdd = 0;
    afterReset = 1'b1;
    afterGap = 1'b0;
  endtask

  task automatic sweep();
    for (int i = 0; i < 256; i++) begin
      step(1'b1, (i >> 4) - 8, (i & 15) - 8);
      if (i % 7 == 3) step(1'b0, 0, 0);
      if (i % 29 == 5) begin step(1'b0, 5, -3); step(1'b0, -8, 7); end
    end
    repeat (4) step(1'b0, 0, 0);
    check(rdPtr == wrPtr, "R4", rdPtr, wrPtr);
  endtask

  initial begin
    resetWith(1, 0, 0, 0);   sweep();
    resetWith(0, 0, 0, 1);   sweep();
    resetWith(7, -8, 3, -5); sweep();
    resetWith(-8, 7, -8, 7); sweep();
    resetWith(-8, -8, -8, -8); sweep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wait (cycle > 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", cycle, 100000);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule